// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical byte address onto one of four DRAM chip-select rows. Each row owns an 8-bit boundary register that holds the cumulative top of that row in 16 MB units. The rows are stacked from address zero upward, so the floor of a row is the top of the row before it. Rows may have different sizes, any multiple of 16 MB. A row whose boundary does not rise above the previous boundary has no size: it is reported as unpopulated and is never chosen.

Software programs the boundaries through a byte-wide write port. Requests arrive as an address with a valid strobe. One cycle later the block returns a registered answer: a one-hot row select, the binary row number and a hit flag. A per-row populated vector is always visible. A two-state machine sequences the result. `ST_IDLE` moves to `ST_RESULT` on a strobe. `ST_RESULT` stays in `ST_RESULT` on a further strobe and returns to `ST_IDLE` otherwise. `ST_IDLE` stays in `ST_IDLE` while no strobe arrives. The response valid is high only in `ST_RESULT`.

Top module: `row_boundary_decoder`

## Requirements
- R1: After reset all four boundaries are 0, `row_populated` is 0, `rsp_valid` is 0, and any address misses.
- R2: With `cfg_we` high, `cfg_wdata` is stored into the boundary of row `cfg_sel` (0 to 3 name rows 0 to 3). The new value is used from the next clock edge.
- R3: `row_populated[i]` is 1 exactly when boundary i is greater than boundary i-1. Row 0 is compared against 0.
- R4: An address hits row i when `addr[31:24]` is at least boundary i-1 (0 for row 0) and below boundary i.
- R5: `rsp_valid` rises one cycle after `req_valid` and stays high for exactly one cycle per strobe. Back-to-back strobes give back-to-back responses.
- R6: On a hit, `rsp_row_onehot` has only bit i set, `rsp_row_idx` equals i and `rsp_hit` is 1. On a miss all three are 0.
- R7: An address at or above the row 3 limit misses.
- R8: A boundary lower than or equal to the previous one makes its row empty. The row never wraps and is never selected. Where ranges overlap, the lowest-numbered matching row wins.
- R9: While no strobe arrives, `rsp_row_onehot`, `rsp_row_idx` and `rsp_hit` hold their last values.
- R10: A request in the same cycle as a boundary write is decoded with the boundaries from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Boundary write enable |
| cfg_sel | input | 2 | Row whose boundary is written |
| cfg_wdata | input | 8 | Boundary value in 16 MB units |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 32 | Physical address to decode |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_row_onehot | output | 4 | One-hot selected row |
| rsp_row_idx | output | 2 | Selected row number |
| rsp_hit | output | 1 | Address fell inside a populated row |
| row_populated | output | 4 | Per-row non-empty flag |

## Verification
Assertions check the following on every cycle:
- the one-hot select has at most one bit set and agrees with the index and the hit flag;
- the response valid follows the strobe by one cycle;
- results hold between strobes;
- a boundary write lands in the addressed register;
- an unpopulated row never raises its match.

Only the directed scenarios can show that the ranges are placed correctly. They probe the exact edges of the rows, empty and descending boundaries, overlap priority, addresses above the last row, and a request that coincides with a write.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rbd_state_e;
endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
    parameter int NUM_ROWS = 4,
    parameter int BND_W    = 8,
    parameter int SEL_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [SEL_W-1:0]                   cfg_sel,
    input  logic [BND_W-1:0]                   cfg_wdata,
    output logic [NUM_ROWS-1:0][BND_W-1:0]     bnd_q
);
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bnd_q[i] <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(i)) begin
                bnd_q[i] <= cfg_wdata;
            end
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == SEL_W'(i)) |=> (bnd_q[i] == $past(cfg_wdata))); // R2
    end
endmodule

// File: rtl/rbd_row_cmp.sv
module rbd_row_cmp #(
    parameter int NUM_ROWS = 4,
    parameter int BND_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [BND_W-1:0]               addr_top,
    input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    output logic [NUM_ROWS-1:0]            hit_vec,
    output logic [NUM_ROWS-1:0]            populated
);
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        logic [BND_W-1:0] floor_v;
        if (i == 0) begin : g_first
            assign floor_v = '0;
        end else begin : g_next
            assign floor_v = bnd[i-1];
        end

        assign populated[i] = bnd[i] > floor_v;
        assign hit_vec[i]   = (addr_top >= floor_v) && (addr_top < bnd[i]);

        AST_EMPTY_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            !populated[i] |-> !hit_vec[i]); // R8
    end
endmodule

// File: rtl/rbd_prio.sv
module rbd_prio #(
    parameter int NUM_ROWS = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_ROWS-1:0] hit_vec,
    output logic [NUM_ROWS-1:0] onehot,
    output logic [IDX_W-1:0]    idx,
    output logic                any
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder
    import rbd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BND_W    = 8,
    parameter int NUM_ROWS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_ROWS)-1:0]   cfg_sel,
    input  logic [BND_W-1:0]              cfg_wdata,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          rsp_valid,
    output logic [NUM_ROWS-1:0]           rsp_row_onehot,
    output logic [$clog2(NUM_ROWS)-1:0]   rsp_row_idx,
    output logic                          rsp_hit,
    output logic [NUM_ROWS-1:0]           row_populated
);
    localparam int IDX_W = $clog2(NUM_ROWS);
    localparam int SHIFT = ADDR_W - BND_W;

    logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
    logic [NUM_ROWS-1:0]            hit_vec;
    logic [NUM_ROWS-1:0]            sel_d;
    logic [IDX_W-1:0]               idx_d;
    logic                           hit_d;
    rbd_state_e                     state_q;

    rbd_bound_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .SEL_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bnd_q(bnd)
    );

    rbd_row_cmp #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .addr_top(req_addr[ADDR_W-1:SHIFT]),
        .bnd(bnd), .hit_vec(hit_vec), .populated(row_populated)
    );

    rbd_prio #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_prio (
        .hit_vec(hit_vec), .onehot(sel_d), .idx(idx_d), .any(hit_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_q <= req_valid ? ST_RESULT : ST_IDLE;
                ST_RESULT: state_q <= req_valid ? ST_RESULT : ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_row_onehot <= '0;
            rsp_row_idx    <= '0;
            rsp_hit        <= 1'b0;
        end else if (req_valid) begin
            rsp_row_onehot <= sel_d;
            rsp_row_idx    <= idx_d;
            rsp_hit        <= hit_d;
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_RESULT: rsp_valid = 1'b1;
            default:   rsp_valid = 1'b0;
        endcase
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_row_onehot)); // R6
    AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_row_onehot[rsp_row_idx]); // R6
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_row_onehot == '0 && rsp_row_idx == '0)); // R6
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R5
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_row_onehot) && $stable(rsp_hit) && $stable(rsp_row_idx))); // R9
endmodule

// File: tb/row_boundary_decoder_test.sv
module row_boundary_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_row_onehot;
    logic [1:0]  rsp_row_idx;
    logic        rsp_hit;
    logic [3:0]  row_populated;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] bm [4];

    always #4 clk = ~clk;

    row_boundary_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_row_onehot(rsp_row_onehot),
        .rsp_row_idx(rsp_row_idx), .rsp_hit(rsp_hit), .row_populated(row_populated)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_pop();
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = bm[i] > ((i == 0) ? 8'd0 : bm[i-1]);
        return p;
    endfunction

    function automatic int exp_row(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] fl;
            fl = (i == 0) ? 8'd0 : bm[i-1];
            if (a[31:24] >= fl && a[31:24] < bm[i]) return i;
        end
        return -1;
    endfunction

    task automatic wr(input int row, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(row); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        bm[row] = v;
    endtask

    task automatic req_chk(input string req, input logic [31:0] a);
        int r;
        r = exp_row(a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit"}, 32'(rsp_hit), (r >= 0) ? 32'd1 : 32'd0);
        chk({req, " onehot"}, 32'(rsp_row_onehot), (r >= 0) ? (32'd1 << r) : 32'd0);
        chk({req, " idx"}, 32'(rsp_row_idx), (r >= 0) ? 32'(r) : 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 populated", 32'(row_populated), 32'd0);
        chk("R1 valid", 32'(rsp_valid), 32'd0);
        req_chk("R1 miss", 32'h0000_0000);
        req_chk("R1 miss high", 32'h0500_0000);
    endtask

    task automatic t_stack();
        wr(0, 8'd1); wr(1, 8'd3); wr(2, 8'd7); wr(3, 8'd15);
        chk("R2 R3 populated", 32'(row_populated), 32'hF);
        req_chk("R4 row0 low", 32'h0000_0000);
        req_chk("R4 row0 top", 32'h00FF_FFFF);
        req_chk("R4 row1 base", 32'h0100_0000);
        req_chk("R4 row1 top", 32'h02FF_FFFF);
        req_chk("R4 row2 base", 32'h0300_0000);
        req_chk("R6 row3", 32'h0EFF_FFFF);
        req_chk("R7 at limit", 32'h0F00_0000);
        req_chk("R7 far above", 32'hFFFF_FFFF);
    endtask

    task automatic t_empty_row();
        wr(1, 8'd1);
        chk("R3 empty row1", 32'(row_populated), 32'b1101);
        req_chk("R3 R4 skip empty", 32'h0100_0000);
        req_chk("R8 empty not chosen", 32'h0000_1000);
    endtask

    task automatic t_descending();
        wr(0, 8'd4); wr(1, 8'd2); wr(2, 8'd1); wr(3, 8'd8);
        chk("R8 populated", 32'(row_populated), 32'b1001);
        req_chk("R8 overlap lowest wins", 32'h0100_0000);
        req_chk("R8 row3", 32'h0500_0000);
        req_chk("R8 no wrap", 32'h0900_0000);
    endtask

    task automatic t_hold();
        req_chk("R5 single", 32'h0600_0000);
        repeat (3) @(negedge clk);
        chk("R5 drop", 32'(rsp_valid), 32'd0);
        chk("R9 hold onehot", 32'(rsp_row_onehot), 32'b1000);
        chk("R9 hold idx", 32'(rsp_row_idx), 32'd3);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0000;
        @(negedge clk);
        req_addr = 32'h0700_0000;
        chk("R5 b2b first", 32'(rsp_row_idx), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 b2b valid", 32'(rsp_valid), 32'd1);
        chk("R5 b2b second", 32'(rsp_row_idx), 32'd3);
        @(negedge clk);
        chk("R5 b2b end", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'd5;
        req_valid = 1'b1; req_addr = 32'h0600_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        bm[3] = 8'd5;
        chk("R10 old boundary", 32'(rsp_row_onehot), 32'b1000);
        req_chk("R10 new boundary", 32'h0600_0000);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) bm[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stack();
        t_empty_row();
        t_descending();
        t_hold();
        t_back_to_back();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule